// File: doc/BRIEF.md
# Shared-Timer Pin Debouncer

This block cleans up the input levels of one 32-pin bank. Every pin first passes through a multi-flop synchronizer. It then goes through a filter that lets a new level through only after that level has held steady for a programmable number of clock cycles. The periods are not stored per pin. A small pool of three period registers is shared by the whole bank, and each pin carries a 2-bit code that names one of them. Code 0 bypasses filtering for that pin.

Software writes the three period registers and the two code registers through a simple write port. Deciding which pin gets which period, and rounding a wanted time up to a whole cycle count, is left to software. The filtered levels leave the block on `pin_db`. Edge detection and level readback further down the chip should use these levels, not the raw pins.

Top module: `dbnc_pool`

## Requirements
- R1: After reset all period registers and all pin codes are zero. `pin_db` is all zeros while the pins are held low.
- R2: A pin whose code is 0 follows its input with no filtering. If `pin_in` changes before clock edge e and holds, `pin_db` shows the new level right after edge e+2.
- R3: A pin's code has two bits. The upper bit is written at address 0x40 and the lower bit at address 0x44, each at the bit position equal to the pin index. Code n (1 to 3) selects period register n.
- R4: Period registers 1, 2 and 3 are written at addresses 0x50, 0x54 and 0x58. Each holds a cycle count P.
- R5: With period P (P > 0) selected, suppose `pin_in` changes before edge e and then holds. `pin_db` keeps the old level through edge e+1+P and takes the new level at edge e+2+P.
- R6: A pulse is filtered when the input holds its new level for P cycles or fewer. A pulse of P+1 cycles reaches `pin_db`.
- R7: If the input returns to the filtered level before the period expires, the count is dropped. A later change waits the full period again, measured from that change.
- R8: A selected period register holding 0 behaves like code 0, with the same latency as R2.
- R9: A period register written while a pin is counting does not affect that count. The value is taken when the count starts.
- R10: Pins filter independently. Several pins may share one period register, and pins on different codes settle at their own times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| pin_in | input | 32 | Raw asynchronous pin levels |
| pin_db | output | 32 | Filtered pin levels, registered |

## Verification
The hardest case to reach is the exact filter boundary. The bench drives a pulse of exactly P cycles, which must vanish, and one of P+1 cycles, which must pass. It also makes a single-cycle return to the old level in the middle of a count, which must restart the period. All of these are timed from the negative clock edge so that the input is caught at a known edge. Rewriting a period register while a pin is counting is reached by issuing the write a few cycles after the pin change. The bench then checks that the settle time still matches the old value.

// File: rtl/dbp_pkg.sv
`timescale 1ns/1ps
package dbp_pkg;
  localparam int TMR_CNT = 3;
  localparam int CODE_W  = 2;
  typedef logic [CODE_W-1:0] sel_code_t;
endpackage

// File: rtl/dbp_sync.sv
`timescale 1ns/1ps
module dbp_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbp_regs.sv
`timescale 1ns/1ps
module dbp_regs
  import dbp_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEL_HI_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] SEL_LO_ADDR = 8'h44,
  parameter logic [ADDR_W-1:0] TMR_BASE    = 8'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0]  tmr_reload [TMR_CNT],
  output sel_code_t         pin_code   [NPINS]
);
  logic [NPINS-1:0] sel_hi_q, sel_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_hi_q <= '0;
      sel_lo_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == SEL_HI_ADDR) sel_hi_q <= cfg_wdata[NPINS-1:0];
      if (cfg_addr == SEL_LO_ADDR) sel_lo_q <= cfg_wdata[NPINS-1:0];
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_code
    assign pin_code[p] = {sel_hi_q[p], sel_lo_q[p]};
  end

  for (genvar t = 0; t < TMR_CNT; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] TADDR = ADDR_W'(TMR_BASE + 4 * t);
    logic [CNT_W-1:0] tmr_q;
    always_ff @(posedge clk) begin
      if (rst)                              tmr_q <= '0;
      else if (cfg_wr && cfg_addr == TADDR) tmr_q <= cfg_wdata[CNT_W-1:0];
    end
    assign tmr_reload[t] = tmr_q;

    // R4
    tmr_write_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && cfg_addr == TADDR) |=> (tmr_q == $past(cfg_wdata[CNT_W-1:0])));
  end

  // R3
  sel_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_addr == SEL_LO_ADDR) |=> (sel_lo_q == $past(cfg_wdata[NPINS-1:0])));
endmodule

// File: rtl/dbp_lane.sv
`timescale 1ns/1ps
module dbp_lane
  import dbp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  sel_code_t        code,
  input  logic [CNT_W-1:0] reload,
  output logic             db_out
);
  logic             out_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (code == '0) begin
      out_q  <= sync_in;
      busy_q <= 1'b0;
    end else if (sync_in == out_q) begin
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (reload == '0) begin
        out_q <= sync_in;
      end else begin
        cnt_q  <= reload - CNT_W'(1);
        busy_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      out_q  <= sync_in;
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign db_out = out_q;

  // R6
  out_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> (out_q == $past(sync_in)));

  // R5
  hold_while_count_chk: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && busy_q && sync_in != out_q && cnt_q != '0) |=> $stable(out_q));

  // R7
  abandon_chk: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && busy_q && sync_in == out_q) |=> !busy_q);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (code != '0 && busy_q && sync_in != out_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/dbnc_pool.sv
`timescale 1ns/1ps
module dbnc_pool
  import dbp_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_db
);
  logic [CNT_W-1:0] tmr_reload [TMR_CNT];
  sel_code_t        pin_code   [NPINS];
  logic [NPINS-1:0] pin_sync;

  dbp_regs #(
    .NPINS(NPINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tmr_reload(tmr_reload), .pin_code(pin_code)
  );

  dbp_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [CNT_W-1:0] pick;
    always_comb begin
      case (pin_code[p])
        2'd1:    pick = tmr_reload[0];
        2'd2:    pick = tmr_reload[1];
        2'd3:    pick = tmr_reload[2];
        default: pick = '0;
      endcase
    end

    dbp_lane #(.CNT_W(CNT_W)) lane_i (
      .clk(clk), .rst(rst), .sync_in(pin_sync[p]), .code(pin_code[p]),
      .reload(pick), .db_out(pin_db[p])
    );
  end
endmodule

// File: tb/dbnc_pool_tb.sv
`timescale 1ns/1ps
module dbnc_pool_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] pin_db;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dbnc_pool dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_in(pins), .pin_db(pin_db)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check(pin_db, 32'h0, "R1 reset output");
    pins[3] = 1'b1;
    step(3);
    check(pin_db, 32'h8, "R1 codes zero after reset");
    pins[3] = 1'b0;
    step(3);
  endtask

  task automatic t_passthrough();
    pins = 32'hA5A5_0F0F;
    step(2);
    check(pin_db, 32'h0, "R2 not before edge e+2");
    step(1);
    check(pin_db, 32'hA5A5_0F0F, "R2 pass-through");
    pins = 32'h0;
    step(3);
    check(pin_db, 32'h0, "R2 pass-through falling");
  endtask

  task automatic t_timer();
    wr(8'h50, 32'd5);
    wr(8'h40, 32'h0);
    wr(8'h44, 32'h1);
    pins[0] = 1'b1;
    step(7);
    check(pin_db[0], 1'b0, "R5 R3 R4 rise held off");
    step(1);
    check(pin_db[0], 1'b1, "R5 rise at e+2+P");
    pins[0] = 1'b0;
    step(7);
    check(pin_db[0], 1'b1, "R5 fall held off");
    step(1);
    check(pin_db[0], 1'b0, "R5 fall at e+2+P");
  endtask

  task automatic t_filter();
    logic seen = 1'b0;
    pins[0] = 1'b1;
    step(5);
    pins[0] = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (pin_db[0]) seen = 1'b1;
    end
    check(seen, 1'b0, "R6 pulse of P cycles filtered");
    pins[0] = 1'b1;
    step(6);
    pins[0] = 1'b0;
    step(2);
    check(pin_db[0], 1'b1, "R6 pulse of P+1 cycles passes");
    step(20);
    check(pin_db[0], 1'b0, "R6 returns low");
  endtask

  task automatic t_restart();
    pins[0] = 1'b1;
    step(3);
    pins[0] = 1'b0;
    step(1);
    pins[0] = 1'b1;
    step(7);
    check(pin_db[0], 1'b0, "R7 count restarted");
    step(1);
    check(pin_db[0], 1'b1, "R7 full period after restart");
    pins[0] = 1'b0;
    step(10);
  endtask

  task automatic t_zero();
    wr(8'h54, 32'd0);
    wr(8'h40, 32'h2);
    pins[1] = 1'b1;
    step(2);
    check(pin_db[1], 1'b0, "R8 not before e+2");
    step(1);
    check(pin_db[1], 1'b1, "R8 zero period acts as bypass");
  endtask

  task automatic t_midwrite();
    wr(8'h58, 32'd10);
    wr(8'h40, 32'h6);
    wr(8'h44, 32'h5);
    pins[2] = 1'b1;
    step(3);
    wr(8'h58, 32'd100);
    step(8);
    check(pin_db[2], 1'b0, "R9 old period still counting");
    step(1);
    check(pin_db[2], 1'b1, "R9 period latched at count start");
  endtask

  task automatic t_indep();
    wr(8'h44, 32'h15);
    pins = 32'h0;
    step(120);
    check(pin_db, 32'h0, "R10 settled low");
    pins = 32'h1F;
    step(3);
    check(pin_db & 32'h1F, 32'h0A, "R10 bypass pins first");
    step(5);
    check(pin_db & 32'h1F, 32'h1B, "R10 shared period pins together");
    step(94);
    check(pin_db[2], 1'b0, "R10 long period still counting");
    step(1);
    check(pin_db & 32'h1F, 32'h1F, "R10 long period settles");
  endtask

  initial begin
    #800000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_passthrough();
    t_timer();
    t_filter();
    t_restart();
    t_zero();
    t_midwrite();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule